// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vectorised integer load into a stream of per-element memory requests. A single-cycle start pulse captures the vector length, the access size, the base-operand kind, a scalar base value, a register number, a byte-swap request and the current little-endian mode bit. From then on the sequencer issues one beat per element over a valid/ready handshake. Each beat carries a 64-bit address, the element number and a flag that tells the load unit whether to swap the bytes of the loaded value.

Two addressing modes share the same element loop. With a scalar base, each address is the base plus the element number times the access size. With a vectorised base, the sequencer reads a 64-bit value for each element from the integer register file, one read per element, and issues that value as the address with no offset added. The register number advances by one for each element. The register file answers one or more cycles after the read request.

The controller has five states. SQ_IDLE waits for start and goes to SQ_DONE on an empty vector, to SQ_FETCH for a vectorised base, or to SQ_ISSUE for a scalar base. SQ_FETCH drives the read request for one cycle and then moves to SQ_WAIT. SQ_WAIT holds until the read data is flagged valid and then moves to SQ_ISSUE. SQ_ISSUE presents a beat until it is accepted. On acceptance it goes to SQ_DONE after the last element, back to SQ_FETCH in vectorised mode, or stays in SQ_ISSUE for the next strided element. SQ_DONE raises done for one cycle and returns to SQ_IDLE.

Top module: `vld_addr_seq`

## Requirements
- R1: Beats carry element numbers 0, 1, ..., VL-1 in that order, exactly one accepted beat per element, for a vector length VL from 0 to 64.
- R2: With `base_vec_i` = 0, the address of element i is `base_scalar_i + i*S`, where `width_i` encodes S as 2'b00 = 1, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8 bytes.
- R3: With `base_vec_i` = 1, the read for element i addresses register `base_reg_i + i` (mod 128), and the address issued for element i equals the 64-bit data returned for that read, with no stride added.
- R4: Every beat's `elem_brev_o` equals the XNOR of the captured `brev_i` and `le_i`.
- R5: A start with VL = 0 produces no beat and raises `done_o` in the cycle after the start.
- R6: In vectorised mode exactly one read request is made per element, and no beat is valid in the request cycle or before the read data is flagged valid.
- R7: While `elem_valid_o` is high and `elem_ready_i` is low, the beat stays valid and its address, index and flag do not change.
- R8: `done_o` is a one-cycle pulse, raised in the cycle after the last beat is accepted.
- R9: A start pulse that arrives while a sequence is running is ignored: the running sequence finishes with its own parameters and no second sequence follows.
- R10: Strided addresses wrap modulo 2^64.
- R11: After reset no beat is valid, no read is requested and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| vl_i | input | 7 | Vector length, 0 to 64 |
| width_i | input | 2 | Access size code (1, 2, 4, 8 bytes) |
| base_vec_i | input | 1 | 1 = vectorised base register, 0 = scalar base |
| base_scalar_i | input | 64 | Scalar base address |
| base_reg_i | input | 7 | First register number of the vectorised base |
| brev_i | input | 1 | Byte-reverse request |
| le_i | input | 1 | Little-endian mode bit |
| rf_req_o | output | 1 | Register-file read request |
| rf_addr_o | output | 7 | Register number to read |
| rf_valid_i | input | 1 | Read data valid |
| rf_data_i | input | 64 | Read data |
| elem_valid_o | output | 1 | Beat valid |
| elem_ready_i | input | 1 | Beat accepted when high with valid |
| elem_addr_o | output | 64 | Element address |
| elem_idx_o | output | 6 | Element number |
| elem_brev_o | output | 1 | Byte-swap flag for the element |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach is a vectorised-base sequence in which register-file latency, a stalling consumer and a stray start pulse all overlap. In that case the fetch, wait and issue states must keep the right element number across many idle cycles. The stimulus draws a random read latency of one to three cycles for every request and a random ready for every cycle, so back-pressure lands both on the beat and on the cycles around each fetch. A directed run injects a start with different parameters part-way through a sequence. Further directed runs cover VL = 0 in both modes, the full 64 elements with a register number that wraps past 127, and a scalar base just below 2^64.

// File: rtl/vldseq_pkg.sv
package vldseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_WAIT,
        SQ_ISSUE,
        SQ_DONE
    } sq_state_e;

endpackage

// File: rtl/vldseq_ctrl.sv
module vldseq_ctrl
    import vldseq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic vl_zero_i,
    input  logic vec_i,
    input  logic vec_q_i,
    input  logic last_i,
    input  logic rf_valid_i,
    input  logic elem_ready_i,
    output logic load_o,
    output logic step_o,
    output logic capture_o,
    output logic elem_valid_o,
    output logic rf_req_o,
    output logic done_o
);

    sq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SQ_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i) begin
                    if (vl_zero_i)  state_d = SQ_DONE;
                    else if (vec_i) state_d = SQ_FETCH;
                    else            state_d = SQ_ISSUE;
                end
            end
            SQ_FETCH: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (rf_valid_i) state_d = SQ_ISSUE;
            end
            SQ_ISSUE: begin
                if (elem_ready_i) begin
                    if (last_i)       state_d = SQ_DONE;
                    else if (vec_q_i) state_d = SQ_FETCH;
                    else              state_d = SQ_ISSUE;
                end
            end
            SQ_DONE: state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o       = 1'b0;
        step_o       = 1'b0;
        capture_o    = 1'b0;
        elem_valid_o = 1'b0;
        rf_req_o     = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            SQ_IDLE:  load_o = start_i;
            SQ_FETCH: rf_req_o = 1'b1;
            SQ_WAIT:  capture_o = rf_valid_i;
            SQ_ISSUE: begin
                elem_valid_o = 1'b1;
                step_o       = elem_ready_i;
            end
            SQ_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vldseq_dpath.sv
module vldseq_dpath #(
    parameter int ADDR_W = 64,
    parameter int VL_W   = 7,
    parameter int REG_W  = 7,
    parameter int WC_W   = 2,
    localparam int IDX_W = VL_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              capture_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [WC_W-1:0]   width_i,
    input  logic              base_vec_i,
    input  logic [ADDR_W-1:0] base_scalar_i,
    input  logic [REG_W-1:0]  base_reg_i,
    input  logic              brev_i,
    input  logic              le_i,
    input  logic [ADDR_W-1:0] rf_data_i,
    output logic              vec_q_o,
    output logic              last_o,
    output logic [REG_W-1:0]  rf_addr_o,
    output logic [ADDR_W-1:0] elem_addr_o,
    output logic [IDX_W-1:0]  elem_idx_o,
    output logic              elem_brev_o
);

    logic [VL_W-1:0]   idx_q, vl_q, idx_nxt;
    logic [WC_W-1:0]   wc_q;
    logic [REG_W-1:0]  reg_q;
    logic [ADDR_W-1:0] addr_q, stride;
    logic              vec_q, swap_q;

    assign idx_nxt = idx_q + VL_W'(1);
    assign stride  = ADDR_W'(1) << wc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q  <= '0;
            vl_q   <= '0;
            wc_q   <= '0;
            reg_q  <= '0;
            addr_q <= '0;
            vec_q  <= 1'b0;
            swap_q <= 1'b0;
        end else if (load_i) begin
            idx_q  <= '0;
            vl_q   <= vl_i;
            wc_q   <= width_i;
            reg_q  <= base_reg_i;
            addr_q <= base_scalar_i;
            vec_q  <= base_vec_i;
            swap_q <= ~(brev_i ^ le_i);
        end else begin
            if (step_i) begin
                idx_q <= idx_nxt;
                if (!vec_q) addr_q <= addr_q + stride;
            end
            if (capture_i) addr_q <= rf_data_i;
        end
    end

    assign vec_q_o     = vec_q;
    assign last_o      = (idx_nxt == vl_q);
    assign rf_addr_o   = reg_q + REG_W'(idx_q);
    assign elem_addr_o = addr_q;
    assign elem_idx_o  = idx_q[IDX_W-1:0];
    assign elem_brev_o = swap_q;

endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq #(
    parameter int ADDR_W = 64,
    parameter int VL_W   = 7,
    parameter int REG_W  = 7,
    parameter int WC_W   = 2,
    localparam int IDX_W = VL_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [WC_W-1:0]   width_i,
    input  logic              base_vec_i,
    input  logic [ADDR_W-1:0] base_scalar_i,
    input  logic [REG_W-1:0]  base_reg_i,
    input  logic              brev_i,
    input  logic              le_i,
    output logic              rf_req_o,
    output logic [REG_W-1:0]  rf_addr_o,
    input  logic              rf_valid_i,
    input  logic [ADDR_W-1:0] rf_data_i,
    output logic              elem_valid_o,
    input  logic              elem_ready_i,
    output logic [ADDR_W-1:0] elem_addr_o,
    output logic [IDX_W-1:0]  elem_idx_o,
    output logic              elem_brev_o,
    output logic              done_o
);

    logic load, step, capture, vec_q, last;

    vldseq_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .vl_zero_i    (vl_i == '0),
        .vec_i        (base_vec_i),
        .vec_q_i      (vec_q),
        .last_i       (last),
        .rf_valid_i   (rf_valid_i),
        .elem_ready_i (elem_ready_i),
        .load_o       (load),
        .step_o       (step),
        .capture_o    (capture),
        .elem_valid_o (elem_valid_o),
        .rf_req_o     (rf_req_o),
        .done_o       (done_o)
    );

    vldseq_dpath #(
        .ADDR_W (ADDR_W),
        .VL_W   (VL_W),
        .REG_W  (REG_W),
        .WC_W   (WC_W)
    ) u_dpath (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .load_i        (load),
        .step_i        (step),
        .capture_i     (capture),
        .vl_i          (vl_i),
        .width_i       (width_i),
        .base_vec_i    (base_vec_i),
        .base_scalar_i (base_scalar_i),
        .base_reg_i    (base_reg_i),
        .brev_i        (brev_i),
        .le_i          (le_i),
        .rf_data_i     (rf_data_i),
        .vec_q_o       (vec_q),
        .last_o        (last),
        .rf_addr_o     (rf_addr_o),
        .elem_addr_o   (elem_addr_o),
        .elem_idx_o    (elem_idx_o),
        .elem_brev_o   (elem_brev_o)
    );

endmodule

// File: rtl/vld_addr_seq_chk.sv
module vld_addr_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              elem_valid_o,
    input logic              elem_ready_i,
    input logic [ADDR_W-1:0] elem_addr_o,
    input logic [IDX_W-1:0]  elem_idx_o,
    input logic              elem_brev_o,
    input logic              rf_req_o,
    input logic              done_o
);

    logic             seen_q;
    logic [IDX_W-1:0] next_idx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q     <= 1'b0;
            next_idx_q <= '0;
        end else if (done_o) begin
            seen_q <= 1'b0;
        end else if (elem_valid_o && elem_ready_i) begin
            seen_q     <= 1'b1;
            next_idx_q <= elem_idx_o + IDX_W'(1);
        end
    end

    AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(elem_addr_o)
            && $stable(elem_idx_o) && $stable(elem_brev_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8

    AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !elem_valid_o && !rf_req_o); // R8

    AST_FETCH_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_req_o |=> !elem_valid_o); // R6

    AST_FIRST_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        elem_valid_o && !seen_q |-> elem_idx_o == '0); // R1

    AST_INDEX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        elem_valid_o && seen_q |-> elem_idx_o == next_idx_q); // R1

endmodule

bind vld_addr_seq vld_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .elem_valid_o (elem_valid_o),
    .elem_ready_i (elem_ready_i),
    .elem_addr_o  (elem_addr_o),
    .elem_idx_o   (elem_idx_o),
    .elem_brev_o  (elem_brev_o),
    .rf_req_o     (rf_req_o),
    .done_o       (done_o)
);

// File: tb/vld_addr_seq_test.sv
`timescale 1ns/1ps
module vld_addr_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  width_i = '0;
    logic        base_vec_i = 1'b0;
    logic [63:0] base_scalar_i = '0;
    logic [6:0]  base_reg_i = '0;
    logic        brev_i = 1'b0;
    logic        le_i = 1'b0;
    logic        rf_req_o;
    logic [6:0]  rf_addr_o;
    logic        rf_valid_i = 1'b0;
    logic [63:0] rf_data_i = '0;
    logic        elem_valid_o;
    logic        elem_ready_i = 1'b0;
    logic [63:0] elem_addr_o;
    logic [5:0]  elem_idx_o;
    logic        elem_brev_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vld_addr_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i),
        .width_i(width_i), .base_vec_i(base_vec_i), .base_scalar_i(base_scalar_i),
        .base_reg_i(base_reg_i), .brev_i(brev_i), .le_i(le_i),
        .rf_req_o(rf_req_o), .rf_addr_o(rf_addr_o), .rf_valid_i(rf_valid_i),
        .rf_data_i(rf_data_i), .elem_valid_o(elem_valid_o),
        .elem_ready_i(elem_ready_i), .elem_addr_o(elem_addr_o),
        .elem_idx_o(elem_idx_o), .elem_brev_o(elem_brev_o), .done_o(done_o)
    );

    function automatic logic [63:0] rf_model(input logic [6:0] r);
        return {r, 57'h0} ^ ({57'h0, r} * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567;
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic run_seq(input int vl, input logic [1:0] wc, input bit vec,
                           input logic [63:0] base, input logic [6:0] rg,
                           input bit br, input bit le, input bit poke,
                           input string tag);
        int ei = 0;
        int cyc = 0;
        int nreq = 0;
        int rf_cnt = 0;
        bit first = 1'b1;
        bit prev_acc = 1'b0;
        bit held = 1'b0;
        bit fin = 1'b0;
        bit acc;
        logic [6:0]  pend = '0;
        logic [63:0] h_addr = '0;
        logic [5:0]  h_idx = '0;
        logic        h_br = 1'b0;
        logic [63:0] exp_a;
        logic        exp_br = ~(br ^ le);
        @(negedge clk);
        start_i = 1'b1; vl_i = 7'(vl); width_i = wc; base_vec_i = vec;
        base_scalar_i = base; base_reg_i = rg; brev_i = br; le_i = le;
        @(negedge clk);
        while (!fin && cyc < 3000) begin
            cyc++;
            start_i = 1'b0;
            acc = 1'b0;
            if (done_o) begin
                chk(ei == vl, {"R1 element count ", tag}, 64'(ei), 64'(vl));
                if (vl == 0)
                    chk(first, {"R5 done timing ", tag}, 64'(cyc), 64'd1);
                else
                    chk(prev_acc, {"R8 done after last accept ", tag}, 64'(prev_acc), 64'd1);
                if (vec)
                    chk(nreq == vl, {"R6 read count ", tag}, 64'(nreq), 64'(vl));
                if (poke)
                    chk(ei == vl, {"R9 stray start ignored ", tag}, 64'(ei), 64'(vl));
                fin = 1'b1;
                elem_ready_i = 1'b0;
            end else begin
                rf_valid_i = 1'b0;
                if (rf_cnt > 0) begin
                    rf_cnt--;
                    if (rf_cnt == 0) begin
                        rf_valid_i = 1'b1;
                        rf_data_i  = rf_model(pend);
                    end
                end
                if (rf_req_o) begin
                    nreq++;
                    chk(rf_addr_o == rg + 7'(ei), {"R3 read register ", tag},
                        64'(rf_addr_o), 64'(rg + 7'(ei)));
                    chk(!elem_valid_o, {"R6 no beat while fetching ", tag},
                        64'(elem_valid_o), 64'd0);
                    pend   = rf_addr_o;
                    rf_cnt = 1 + int'($urandom % 3);
                end
                if (elem_valid_o) begin
                    if (held) begin
                        chk(elem_addr_o == h_addr && elem_idx_o == h_idx && elem_brev_o == h_br,
                            {"R7 held beat stable ", tag}, elem_addr_o, h_addr);
                    end
                    exp_a = vec ? rf_model(rg + 7'(ei)) : base + (64'(ei) << wc);
                    chk(elem_idx_o == 6'(ei), {"R1 element index ", tag},
                        64'(elem_idx_o), 64'(ei));
                    chk(elem_addr_o == exp_a, {vec ? "R3 address " : "R2 address ", tag},
                        elem_addr_o, exp_a);
                    chk(elem_brev_o == exp_br, {"R4 byte-reverse flag ", tag},
                        64'(elem_brev_o), 64'(exp_br));
                    elem_ready_i = (($urandom % 10) < 7);
                    if (elem_ready_i) begin
                        ei++;
                        acc  = 1'b1;
                        held = 1'b0;
                    end else begin
                        held   = 1'b1;
                        h_addr = elem_addr_o;
                        h_idx  = elem_idx_o;
                        h_br   = elem_brev_o;
                    end
                end else begin
                    elem_ready_i = 1'($urandom % 2);
                    held = 1'b0;
                end
                if (poke && cyc == 3) begin
                    start_i = 1'b1; vl_i = 7'd5; width_i = ~wc; base_vec_i = ~vec;
                    base_scalar_i = 64'hDEAD_0000_BEEF_0000; base_reg_i = rg + 7'd40;
                    brev_i = ~br;
                end
                prev_acc = acc;
                first = 1'b0;
                @(negedge clk);
            end
        end
        if (!fin) chk(1'b0, {"R8 done never raised ", tag}, 64'(cyc), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!elem_valid_o && !rf_req_o && !done_o, "R11 reset state",
            {61'h0, elem_valid_o, rf_req_o, done_o}, 64'd0);

        // directed corner cases
        run_seq(0, 2'd3, 1'b0, 64'h1000, 7'd0, 1'b0, 1'b0, 1'b0, "R5 scalar empty");
        run_seq(0, 2'd0, 1'b1, 64'h0, 7'd9, 1'b1, 1'b0, 1'b0, "R5 vector empty");
        run_seq(1, 2'd0, 1'b0, 64'h55, 7'd0, 1'b1, 1'b1, 1'b0, "single");
        run_seq(64, 2'd3, 1'b0, 64'h8000_0000, 7'd0, 1'b0, 1'b1, 1'b0, "full scalar");
        run_seq(10, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 7'd0, 1'b1, 1'b0, 1'b0, "R10 wrap");
        run_seq(64, 2'd2, 1'b1, 64'h0, 7'd100, 1'b0, 1'b0, 1'b0, "full vector regwrap");
        run_seq(12, 2'd1, 1'b0, 64'h2000, 7'd0, 1'b0, 1'b0, 1'b1, "poke scalar");
        run_seq(8, 2'd1, 1'b1, 64'h0, 7'd3, 1'b1, 1'b1, 1'b1, "poke vector");

        // constrained random
        for (int n = 0; n < 40; n++) begin
            run_seq(int'($urandom % 65), 2'($urandom), 1'($urandom),
                    {$urandom, $urandom}, 7'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom % 4 == 0), "random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule